// File: doc/BRIEF.md
# Return Address Predictor Stack

This block keeps a short circular stack of return addresses so that the front end can predict where a near return will go. Every branch event carries a three-bit kind code, the branch PC, the instruction length and a flag that says whether a call's displacement is zero. A near call with a non-zero displacement pushes the address of the instruction that follows it, which is PC plus length. A near return looks up the top entry and pops it. The prediction is combinational, so it is available in the same cycle as the return event. The stack pointer moves on the next clock edge.

Far calls, far returns, interrupt returns and every other branch kind leave the stack untouched. When more calls arrive than there are entries, the oldest entry is overwritten and the occupancy count stays at the full depth. When the stack is empty, a return gets no prediction and the pointer does not move. A flush input empties the stack in one cycle.

Top module: `rsb_top`

## Requirements
- R1: After reset the stack is empty, so a near return gives predValid low.
- R2: An event with kind 1 (near call) and dispZero low pushes evPc + evLen, taken modulo 2^ADDR_W.
- R3: An event with kind 1 and dispZero high does not push.
- R4: The kinds 3 (far call), 4 (far return), 5 (interrupt return), 0, 6 and 7 neither push nor pop, and they give predValid low.
- R5: An event with kind 2 (near return) on a non-empty stack gives predValid high in the same cycle, with predTarget equal to the most recent surviving push, and it removes that entry at the next clock edge.
- R6: A near return on an empty stack gives predValid low and changes nothing.
- R7: After more than DEPTH pushes, only the last DEPTH addresses remain. The occupancy count never exceeds DEPTH.
- R8: When flush is high, the stack is empty from the next cycle on, and any event in the same cycle has no effect on the stack.
- R9: Entries come back in last-in first-out order, including after pops and pushes are interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the stack |
| evValid | input | 1 | A branch event is present this cycle |
| evType | input | 3 | Branch kind code (see requirements) |
| evPc | input | ADDR_W | Address of the branch instruction |
| evLen | input | LEN_W | Length of the branch instruction in bytes |
| dispZero | input | 1 | The call's displacement is zero |
| predValid | output | 1 | The return target prediction is valid |
| predTarget | output | ADDR_W | Predicted return target |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=16 and LEN_W=4. With only four entries, the wrap of the write pointer, saturation of the count and the oldest entry being overwritten all occur after a few events. The sweep cycles through all eight kind codes with both values of the displacement flag, so every filtering case is exercised at every fill level. With a 16-bit address, the PC + length sum can be driven across its carry out of the top bit.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [2:0] {
    BR_NONE  = 3'd0,
    BR_NCALL = 3'd1,
    BR_NRET  = 3'd2,
    BR_FCALL = 3'd3,
    BR_FRET  = 3'd4,
    BR_IRET  = 3'd5,
    BR_IJMP  = 3'd6,
    BR_OTHER = 3'd7
  } brKind_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } rsbStrobe_t;
endpackage

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
  import rsb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             evValid,
  input  logic [2:0]       evType,
  input  logic             dispZero,
  output rsbStrobe_t       strb,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic [CNT_W-1:0] occ,
  output logic             predValid
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] wrNext;
  logic             isCall;
  logic             isRet;
  logic             nonEmpty;

  always_comb begin
    isCall   = evValid && (brKind_e'(evType) == BR_NCALL) && !dispZero;
    isRet    = evValid && (brKind_e'(evType) == BR_NRET);
    nonEmpty = (occ != '0);
    rdIdx    = (wrPtr == '0) ? LAST_IDX : wrPtr - 1'b1;
    wrNext   = (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
    strb.push  = isCall && !flush;
    strb.pop   = isRet && nonEmpty && !flush;
    strb.clear = flush;
    predValid  = isRet && nonEmpty;
    wrIdx      = wrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      occ   <= '0;
    end else if (strb.clear) begin
      occ <= '0;
    end else if (strb.push) begin
      wrPtr <= wrNext;
      if (occ != FULL_CNT) occ <= occ + 1'b1;
    end else if (strb.pop) begin
      wrPtr <= rdIdx;
      occ   <= occ - 1'b1;
    end
  end
endmodule

// File: rtl/rsb_datapath.sv
module rsb_datapath
  import rsb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  rsbStrobe_t        strb,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic [ADDR_W-1:0] evPc,
  input  logic [LEN_W-1:0]  evLen,
  output logic [ADDR_W-1:0] predTarget
);
  logic [ADDR_W-1:0] slot [DEPTH];
  logic [ADDR_W-1:0] retAddr;

  assign retAddr = evPc + ADDR_W'(evLen);

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strb.push && (wrIdx == PTR_W'(g))) slot[g] <= retAddr;
    end
  end

  assign predTarget = slot[rdIdx];
endmodule

// File: rtl/rsb_top.sv
module rsb_top #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              evValid,
  input  logic [2:0]        evType,
  input  logic [ADDR_W-1:0] evPc,
  input  logic [LEN_W-1:0]  evLen,
  input  logic              dispZero,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rsb_pkg::rsbStrobe_t strb;
  logic [PTR_W-1:0]    wrIdx;
  logic [PTR_W-1:0]    rdIdx;
  logic [CNT_W-1:0]    occ;

  rsb_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .evValid(evValid),
    .evType(evType), .dispZero(dispZero), .strb(strb),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .occ(occ), .predValid(predValid)
  );

  rsb_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) uData (
    .clk(clk), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .evPc(evPc), .evLen(evLen), .predTarget(predTarget)
  );
endmodule

// File: rtl/rsb_chk.sv
module rsb_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             evValid,
  input logic [2:0]       evType,
  input logic             dispZero,
  input logic             predValid,
  input logic [CNT_W-1:0] occ
);
  logic ignoredKind;
  assign ignoredKind = evValid && (evType != 3'd1) && (evType != 3'd2);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNT_W'(DEPTH));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (occ == '0));

  // R4
  other_kind_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ignoredKind && !flush) |=> $stable(occ));

  // R4
  other_kind_nopred_chk: assert property (@(posedge clk) disable iff (!rstN)
    ignoredKind |-> !predValid);

  // R3
  zero_disp_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evType == 3'd1 && dispZero && !flush) |=> $stable(occ));

  // R2
  push_grows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evType == 3'd1 && !dispZero && !flush && occ != CNT_W'(DEPTH))
      |=> (occ == CNT_W'($past(occ) + 1'b1)));

  // R5
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && !flush) |=> (occ == CNT_W'($past(occ) - 1'b1)));

  // R6
  empty_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evType == 3'd2 && occ == '0) |-> !predValid);
endmodule

bind rsb_top rsb_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .flush(flush), .evValid(evValid), .evType(evType),
  .dispZero(dispZero), .predValid(predValid), .occ(occ)
);

// File: tb/tb_rsb_top.sv
`timescale 1ns/1ps
module tb_rsb_top;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              flush = 1'b0;
  logic              evValid = 1'b0;
  logic [2:0]        evType = '0;
  logic [ADDR_W-1:0] evPc = '0;
  logic [LEN_W-1:0]  evLen = '0;
  logic              dispZero = 1'b0;
  logic              predValid;
  logic [ADDR_W-1:0] predTarget;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mdl [DEPTH];
  int mPtr = 0;
  int mCnt = 0;

  always #2.5 clk = ~clk;

  rsb_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .flush(flush), .evValid(evValid), .evType(evType),
    .evPc(evPc), .evLen(evLen), .dispZero(dispZero),
    .predValid(predValid), .predTarget(predTarget)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(input int t, input int dz);
    if (t == 1) return (dz != 0) ? "R3" : "R2";
    if (t == 2) return (mCnt == 0) ? "R6" : "R5/R9";
    return "R4";
  endfunction

  // one event: drive after negedge, sample combinational outputs, update model
  task automatic step(input int t, input int pc, input int len, input int dz,
                      input bit fl, input string tag);
    int top;
    bit expV;
    @(negedge clk);
    evValid = 1'b1; evType = 3'(t); evPc = ADDR_W'(pc); evLen = LEN_W'(len);
    dispZero = dz[0]; flush = fl;
    #1;
    expV = (t == 2) && (mCnt > 0);
    top = (mPtr + DEPTH - 1) % DEPTH;
    chk(tag, int'(predValid), int'(expV));
    if (expV) chk(tag, int'(predTarget), mdl[top]);
    if (fl) mCnt = 0;
    else if (t == 1 && dz == 0) begin
      mdl[mPtr] = (pc + len) % (1 << ADDR_W);
      mPtr = (mPtr + 1) % DEPTH;
      if (mCnt < DEPTH) mCnt++;
    end else if (expV) begin
      mPtr = top;
      mCnt--;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: return straight after reset finds an empty stack
    step(2, 0, 0, 0, 0, "R1");

    // near-exhaustive sweep of kinds and displacement flag at all fill levels
    for (int i = 0; i < 480; i++) begin
      int t  = (i * 5 + i / 8) % 8;
      int dz = (i / 3) % 2;
      int pc = (i * 1237 + 100) % 65536;
      int ln = (i % 15) + 1;
      if (i % 11 == 10) pc = 65535 - (i % 7);   // carry across the top bit
      step(t, pc, ln, dz, 0, tagFor(t, dz));
    end

    // R7: overflow keeps the last DEPTH addresses, then empty
    step(0, 0, 0, 0, 1, "R8");
    for (int k = 0; k < DEPTH + 3; k++) step(1, 16'h1000 + 16 * k, 2, 0, 0, "R7");
    for (int k = 0; k < DEPTH + 1; k++) step(2, 0, 0, 0, 0, "R7");

    // R8: flush wins over a same-cycle call, stack empty afterwards
    step(1, 16'h2000, 3, 0, 0, "R8");
    step(1, 16'h2100, 3, 0, 0, "R8");
    step(1, 16'h2200, 3, 0, 1, "R8");
    step(2, 0, 0, 0, 0, "R8");
    step(1, 16'h2300, 5, 0, 0, "R8");
    step(2, 0, 0, 0, 1, "R8");
    step(2, 0, 0, 0, 0, "R8");

    // R9: interleaved pushes and pops
    step(1, 16'h3000, 4, 0, 0, "R9");
    step(1, 16'h3100, 4, 0, 0, "R9");
    step(2, 0, 0, 0, 0, "R9");
    step(1, 16'h3200, 6, 0, 0, "R9");
    step(2, 0, 0, 0, 0, "R9");
    step(2, 0, 0, 0, 0, "R9");
    step(2, 0, 0, 0, 0, "R6");

    @(negedge clk) evValid = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule